// File: doc/BRIEF.md
# Video Processor Host Port

This block is the processor-facing side of a tile-based video processor. The host sees two byte-wide ports, picked by one select line: a data port and a control port. A pair of control-port writes sets a 14-bit access address and a 2-bit access code. The same pair can also load one of sixteen 8-bit configuration registers. Data-port traffic then streams bytes into video RAM or colour RAM, or fetches video RAM bytes back, and the address steps forward by one after each access.

A status read on the control port returns the frame-interrupt pending flag. That read also clears every pending interrupt flag and restarts the two-byte control sequence. The video RAM and colour RAM sit outside the block and are reached through plain synchronous memory ports. Interrupt events arrive as one-cycle set pulses from the display timing logic.

Top module: `vdp_host_port`

## Requirements
- R1: A control-port write made while the sequence latch is clear replaces address bits 7:0 with the written byte and leaves bits 13:8 unchanged.
- R2: A control-port write made while the sequence latch is set loads bits 5:0 of the byte into address bits 13:8 and bits 7:6 of the byte into the access code.
- R3: Every control-port write toggles the sequence latch, so a third control byte again acts as a low-address byte.
- R4: When the second control byte has bits 7:6 equal to 2, the current address low byte is copied into the configuration register selected by bits 3:0 of that byte. Any other second byte leaves every configuration register unchanged. Register n occupies bits 8n+7:8n of `cfg_regs`.
- R5: A data-port write asserts `cram_we` with `cram_addr` equal to address bits 4:0 when the access code is 3. For any other code it asserts `vram_we` with `vram_addr` equal to the full address. The two enables are never active together, and both are driven in the strobe cycle.
- R6: Every data-port read or write advances the address by one modulo 0x4000 and clears the sequence latch.
- R7: A status read (control port, read strobe) returns a byte whose bit 7 is the frame flag and whose other bits are zero. It clears the sequence latch and both interrupt flags. A set pulse that arrives in the same cycle as the read wins, and that flag stays set.
- R8: A data-port read asserts `vram_re` with the current address in the strobe cycle. `host_rdata` holds the addressed video RAM byte in the following cycle, and the address increments only after the fetch. A read strobe that comes together with a write strobe is ignored.
- R9: After reset the address, access code, sequence latch, both interrupt flags and all configuration registers are zero.
- R10: A one-cycle pulse on `frame_irq_set` or `line_irq_set` sets the matching pending flag from the next cycle. The flag holds until a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_is_ctl | input | 1 | 1 selects the control port, 0 the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after the read strobe |
| vram_addr | output | 14 | Video RAM address (current access address) |
| vram_we | output | 1 | Video RAM write enable |
| vram_re | output | 1 | Video RAM read enable |
| vram_wdata | output | 8 | Video RAM write byte |
| vram_rdata | input | 8 | Video RAM read byte, one cycle after `vram_re` |
| cram_addr | output | 5 | Colour RAM address |
| cram_we | output | 1 | Colour RAM write enable |
| cram_wdata | output | 8 | Colour RAM write byte |
| frame_irq_set | input | 1 | Frame interrupt event pulse |
| line_irq_set | input | 1 | Line interrupt event pulse |
| frame_irq_pend | output | 1 | Frame interrupt pending flag |
| line_irq_pend | output | 1 | Line interrupt pending flag |
| cfg_regs | output | 128 | All configuration registers, register n at bits 8n+7:8n |

## Verification
The bench builds the block with its default parameters: a 14-bit address, a 5-bit colour RAM address and sixteen configuration registers. At these sizes, two control bytes reach the last video RAM location, so wrap from 0x3FFF to 0x0000 takes one further write. The colour RAM index crosses from 31 to 0 within three writes. Both the lowest and the highest configuration register index can be reached directly. A small aliased video RAM model in the bench is enough to compare read-back bytes at both ends of the address space.

// File: rtl/vdp_host_pkg.sv
package vdp_host_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ACC_VREAD   = 2'd0,
        ACC_VWRITE  = 2'd1,
        ACC_REGSET  = 2'd2,
        ACC_PALETTE = 2'd3
    } acc_code_e;

    // One-hot-or-idle host operation for the current cycle
    typedef struct packed {
        logic ctl_wr;
        logic ctl_rd;
        logic dat_wr;
        logic dat_rd;
    } host_op_t;

    // Write strobe wins over a read strobe in the same cycle
    function automatic host_op_t decode_op(input logic wr, input logic rd,
                                           input logic is_ctl);
        host_op_t op;
        op.ctl_wr = wr & is_ctl;
        op.dat_wr = wr & ~is_ctl;
        op.ctl_rd = rd & ~wr & is_ctl;
        op.dat_rd = rd & ~wr & ~is_ctl;
        return op;
    endfunction

    function automatic byte_t status_byte(input logic frame_flag);
        return {frame_flag, 7'b0};
    endfunction

    function automatic logic is_regset(input byte_t b);
        return acc_code_e'(b[7:6]) == ACC_REGSET;
    endfunction

endpackage

// File: rtl/vdp_addr_seq.sv
module vdp_addr_seq
    import vdp_host_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  host_op_t          op,
    input  byte_t             wdata,
    output logic [ADDR_W-1:0] addr,
    output acc_code_e         code,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output byte_t             reg_val
);
    localparam int HI_W = ADDR_W - 8;

    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            code      <= ACC_VREAD;
            pending_q <= 1'b0;
        end else if (op.ctl_wr) begin
            if (pending_q) begin
                addr[ADDR_W-1:8] <= wdata[HI_W-1:0];
                code             <= acc_code_e'(wdata[7:6]);
            end else begin
                addr[7:0] <= wdata;
            end
            pending_q <= ~pending_q;
        end else if (op.dat_wr || op.dat_rd) begin
            addr      <= addr + 1'b1;
            pending_q <= 1'b0;
        end else if (op.ctl_rd) begin
            pending_q <= 1'b0;
        end
    end

    assign reg_we  = op.ctl_wr & pending_q & is_regset(wdata);
    assign reg_idx = wdata[IDX_W-1:0];
    assign reg_val = addr[7:0];

    a_r3_latch_toggles: assert property (@(posedge clk) disable iff (rst)
        op.ctl_wr |=> pending_q != $past(pending_q));

    a_r1_high_kept: assert property (@(posedge clk) disable iff (rst)
        (op.ctl_wr && !pending_q) |=>
            (addr[ADDR_W-1:8] == $past(addr[ADDR_W-1:8])) && (addr[7:0] == $past(wdata)));

    a_r2_high_loaded: assert property (@(posedge clk) disable iff (rst)
        (op.ctl_wr && pending_q) |=>
            (addr[ADDR_W-1:8] == $past(wdata[HI_W-1:0])) &&
            (code == acc_code_e'($past(wdata[7:6]))));

    a_r6_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (op.dat_wr || op.dat_rd) |=>
            (addr == ADDR_W'($past(addr) + 1'b1)) && !pending_q);

    a_r7_latch_cleared: assert property (@(posedge clk) disable iff (rst)
        op.ctl_rd |=> !pending_q);

endmodule

// File: rtl/vdp_cfg_bank.sv
module vdp_cfg_bank
    import vdp_host_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  byte_t                 val,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            byte_t r_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r_q <= '0;
                end else if (we && idx == IDX_W'(g)) begin
                    r_q <= val;
                end
            end
            assign regs_flat[g*8 +: 8] = r_q;
        end
    endgenerate

    a_r4_no_stray_change: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/vdp_irq_flags.sv
module vdp_irq_flags (
    input  logic clk,
    input  logic rst,
    input  logic frame_set,
    input  logic line_set,
    input  logic clear,
    output logic frame_pend,
    output logic line_pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pend <= 1'b0;
            line_pend  <= 1'b0;
        end else begin
            frame_pend <= frame_set | (frame_pend & ~clear);
            line_pend  <= line_set  | (line_pend  & ~clear);
        end
    end

    a_r10_frame_sets: assert property (@(posedge clk) disable iff (rst)
        frame_set |=> frame_pend);

    a_r10_line_sets: assert property (@(posedge clk) disable iff (rst)
        line_set |=> line_pend);

    a_r7_clear_frame: assert property (@(posedge clk) disable iff (rst)
        (clear && !frame_set) |=> !frame_pend);

    a_r7_clear_line: assert property (@(posedge clk) disable iff (rst)
        (clear && !line_set) |=> !line_pend);

endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_host_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int CRAM_AW  = 5,
    parameter int NUM_REGS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic                  host_is_ctl,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic [ADDR_W-1:0]     vram_addr,
    output logic                  vram_we,
    output logic                  vram_re,
    output logic [7:0]            vram_wdata,
    input  logic [7:0]            vram_rdata,
    output logic [CRAM_AW-1:0]    cram_addr,
    output logic                  cram_we,
    output logic [7:0]            cram_wdata,
    input  logic                  frame_irq_set,
    input  logic                  line_irq_set,
    output logic                  frame_irq_pend,
    output logic                  line_irq_pend,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int IDX_W = $clog2(NUM_REGS);

    host_op_t          op;
    logic [ADDR_W-1:0] addr;
    acc_code_e         code;
    logic              reg_we;
    logic [IDX_W-1:0]  reg_idx;
    byte_t             reg_val;
    logic              rd_status_q;
    byte_t             status_q;

    assign op = decode_op(host_wr, host_rd, host_is_ctl);

    vdp_addr_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wdata   (host_wdata),
        .addr    (addr),
        .code    (code),
        .reg_we  (reg_we),
        .reg_idx (reg_idx),
        .reg_val (reg_val)
    );

    vdp_cfg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .idx       (reg_idx),
        .val       (reg_val),
        .regs_flat (cfg_regs)
    );

    vdp_irq_flags u_irq (
        .clk        (clk),
        .rst        (rst),
        .frame_set  (frame_irq_set),
        .line_set   (line_irq_set),
        .clear      (op.ctl_rd),
        .frame_pend (frame_irq_pend),
        .line_pend  (line_irq_pend)
    );

    // Memory routing
    assign vram_addr  = addr;
    assign cram_addr  = addr[CRAM_AW-1:0];
    assign vram_wdata = host_wdata;
    assign cram_wdata = host_wdata;
    assign cram_we    = op.dat_wr & (code == ACC_PALETTE);
    assign vram_we    = op.dat_wr & (code != ACC_PALETTE);
    assign vram_re    = op.dat_rd;

    // Read return: both read kinds answer one cycle after the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_status_q <= 1'b0;
            status_q    <= '0;
        end else if (op.ctl_rd || op.dat_rd) begin
            rd_status_q <= op.ctl_rd;
            status_q    <= status_byte(frame_irq_pend);
        end
    end

    assign host_rdata = rd_status_q ? status_q : vram_rdata;

    a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
        !(vram_we && cram_we));

    a_r7_status_shape: assert property (@(posedge clk) disable iff (rst)
        op.ctl_rd |=> (host_rdata[6:0] == 7'd0) && (host_rdata[7] == $past(frame_irq_pend)));

    a_r8_fetch_issued: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && !host_is_ctl) |-> (vram_re && !vram_we && !cram_we));

endmodule

// File: tb/test_vdp_host_port.sv
module test_vdp_host_port;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_wr = 1'b0;
    logic         host_rd = 1'b0;
    logic         host_is_ctl = 1'b0;
    logic [7:0]   host_wdata = 8'h00;
    logic [7:0]   host_rdata;
    logic [13:0]  vram_addr;
    logic         vram_we;
    logic         vram_re;
    logic [7:0]   vram_wdata;
    logic [7:0]   vram_rdata;
    logic [4:0]   cram_addr;
    logic         cram_we;
    logic [7:0]   cram_wdata;
    logic         frame_irq_set = 1'b0;
    logic         line_irq_set = 1'b0;
    logic         frame_irq_pend;
    logic         line_irq_pend;
    logic [127:0] cfg_regs;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vdp_host_port i_vdp_host_port (
        .clk            (clk),
        .rst            (rst),
        .host_wr        (host_wr),
        .host_rd        (host_rd),
        .host_is_ctl    (host_is_ctl),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .vram_addr      (vram_addr),
        .vram_we        (vram_we),
        .vram_re        (vram_re),
        .vram_wdata     (vram_wdata),
        .vram_rdata     (vram_rdata),
        .cram_addr      (cram_addr),
        .cram_we        (cram_we),
        .cram_wdata     (cram_wdata),
        .frame_irq_set  (frame_irq_set),
        .line_irq_set   (line_irq_set),
        .frame_irq_pend (frame_irq_pend),
        .line_irq_pend  (line_irq_pend),
        .cfg_regs       (cfg_regs)
    );

    // Aliased synchronous video RAM model (1K bytes)
    logic [7:0] vmem [1024];
    logic [7:0] vrd_q = 8'h00;
    always_ff @(posedge clk) begin
        if (vram_we) vmem[vram_addr[9:0]] <= vram_wdata;
        if (vram_re) vrd_q <= vmem[vram_addr[9:0]];
    end
    assign vram_rdata = vrd_q;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Captured port values from the strobe cycle
    logic [13:0] cap_vaddr;
    logic        cap_vwe;
    logic        cap_cwe;
    logic [4:0]  cap_caddr;
    logic [7:0]  cap_cdata;

    task automatic host_cycle(input logic wr, input logic rd, input logic ctl, input logic [7:0] d);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_is_ctl = ctl; host_wdata = d;
        #0.5;
        cap_vaddr = vram_addr; cap_vwe = vram_we; cap_cwe = cram_we;
        cap_caddr = cram_addr; cap_cdata = cram_wdata;
        @(posedge clk);
        #0.5;
        host_wr = 1'b0; host_rd = 1'b0; host_is_ctl = 1'b0;
    endtask

    task automatic ctl_wr(input logic [7:0] d);
        host_cycle(1'b1, 1'b0, 1'b1, d);
    endtask

    task automatic dat_wr(input logic [7:0] d);
        host_cycle(1'b1, 1'b0, 1'b0, d);
    endtask

    task automatic dat_rd(output logic [7:0] q);
        host_cycle(1'b0, 1'b1, 1'b0, 8'h00);
        q = host_rdata;
    endtask

    task automatic stat_rd(output logic [7:0] q);
        host_cycle(1'b0, 1'b1, 1'b1, 8'h00);
        q = host_rdata;
    endtask

    task automatic t_reset;
        chk("R9 addr", 32'(vram_addr), 32'h0);
        chk("R9 cfg", 32'(cfg_regs != 128'd0), 32'h0);
        chk("R9 flags", {30'd0, frame_irq_pend, line_irq_pend}, 32'h0);
        // latch clear: first byte lands in low address
        ctl_wr(8'h2C);
        dat_wr(8'h01);
        chk("R9 latch clear", 32'(cap_vaddr), 32'h002C);
    endtask

    task automatic t_addr_load;
        ctl_wr(8'h34);
        ctl_wr(8'h52);
        dat_wr(8'hAA);
        chk("R2 address", 32'(cap_vaddr), 32'h1234);
        chk("R5 vram target", {30'd0, cap_vwe, cap_cwe}, 32'h2);
        ctl_wr(8'h77);
        dat_wr(8'hBB);
        chk("R1 high kept", 32'(cap_vaddr), 32'h1277);
    endtask

    task automatic t_latch;
        ctl_wr(8'h00); ctl_wr(8'h40);
        ctl_wr(8'h10); ctl_wr(8'h41);
        dat_wr(8'h01);
        chk("R3 latch toggles", 32'(cap_vaddr), 32'h0110);
        ctl_wr(8'h55);
        dat_wr(8'h02);
        chk("R6 step after write", 32'(cap_vaddr), 32'h0155);
        ctl_wr(8'h66);
        dat_wr(8'h03);
        chk("R6 latch cleared", 32'(cap_vaddr), 32'h0166);
    endtask

    task automatic t_regs;
        ctl_wr(8'h0B); ctl_wr(8'h85);
        chk("R4 reg5", 32'(cfg_regs[47:40]), 32'h0B);
        ctl_wr(8'hC3); ctl_wr(8'h8F);
        chk("R4 reg15", 32'(cfg_regs[127:120]), 32'hC3);
        ctl_wr(8'h99); ctl_wr(8'h45);
        chk("R4 non-reg code", 32'(cfg_regs[47:40]), 32'h0B);
        chk("R4 others zero", 32'((cfg_regs & ~{8'hFF, 72'd0, 8'hFF, 40'd0}) == 128'd0), 32'h1);
    endtask

    task automatic t_cram;
        ctl_wr(8'h1E); ctl_wr(8'hC0);
        dat_wr(8'h11);
        chk("R5 cram enable", {30'd0, cap_vwe, cap_cwe}, 32'h1);
        chk("R5 cram addr", {19'd0, cap_caddr, cap_cdata}, {19'd0, 5'h1E, 8'h11});
        dat_wr(8'h22);
        chk("R5 cram addr 31", 32'(cap_caddr), 32'h1F);
        dat_wr(8'h33);
        chk("R5 cram index wraps", 32'(cap_caddr), 32'h00);
    endtask

    task automatic t_wrap_read;
        logic [7:0] q;
        ctl_wr(8'hFF); ctl_wr(8'h7F);
        dat_wr(8'h5A);
        chk("R6 top addr", 32'(cap_vaddr), 32'h3FFF);
        dat_wr(8'hA5);
        chk("R6 wrap", 32'(cap_vaddr), 32'h0000);
        ctl_wr(8'hFF); ctl_wr(8'h3F);
        dat_rd(q);
        chk("R8 read top", 32'(q), 32'h5A);
        chk("R8 read addr", 32'(cap_vaddr), 32'h3FFF);
        dat_rd(q);
        chk("R8 read wrapped", 32'(q), 32'hA5);
        // read strobe together with write: write only
        host_cycle(1'b1, 1'b1, 1'b0, 8'hC7);
        chk("R8 rd ignored with wr", {31'd0, cap_vwe}, 32'h1);
        chk("R8 no fetch with wr", 32'(vram_re), 32'h0);
    endtask

    task automatic pulse(input logic f, input logic l);
        @(negedge clk);
        frame_irq_set = f; line_irq_set = l;
        @(posedge clk);
        #0.5;
        frame_irq_set = 1'b0; line_irq_set = 1'b0;
    endtask

    task automatic t_status;
        logic [7:0] q;
        pulse(1'b1, 1'b0);
        chk("R10 frame set", 32'(frame_irq_pend), 32'h1);
        pulse(1'b0, 1'b1);
        chk("R10 both held", {30'd0, frame_irq_pend, line_irq_pend}, 32'h3);
        stat_rd(q);
        chk("R7 status byte", 32'(q), 32'h80);
        chk("R7 flags cleared", {30'd0, frame_irq_pend, line_irq_pend}, 32'h0);
        stat_rd(q);
        chk("R7 second status", 32'(q), 32'h00);
        pulse(1'b0, 1'b1);
        stat_rd(q);
        chk("R7 line not in byte", 32'(q), 32'h00);
        chk("R7 line cleared", 32'(line_irq_pend), 32'h0);
        // set wins over clear in same cycle
        @(negedge clk);
        frame_irq_set = 1'b1; host_rd = 1'b1; host_is_ctl = 1'b1;
        @(posedge clk);
        #0.5;
        frame_irq_set = 1'b0; host_rd = 1'b0; host_is_ctl = 1'b0;
        chk("R7 collision byte", 32'(host_rdata), 32'h00);
        chk("R7 set wins", 32'(frame_irq_pend), 32'h1);
        // status read restarts control sequence
        ctl_wr(8'h22);
        stat_rd(q);
        ctl_wr(8'h33);
        dat_wr(8'h44);
        chk("R7 latch cleared", 32'(cap_vaddr[7:0]), 32'h33);
        chk("R7 code kept vram", {31'd0, cap_vwe}, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        t_reset();
        t_addr_load();
        t_latch();
        t_regs();
        t_cram();
        t_wrap_read();
        t_status();
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule